// File: doc/BRIEF.md
# Host Bridge Decode Register File

This block is the 32-bit register file of a CPU-to-PCI host bridge. It sits in a 4 KB address window and is reached by word offset: the byte address is cut to its low twelve bits and the two byte-select bits are dropped, which gives 1024 word slots. Most slots are plain storage. A fixed set of slots has its own behaviour: write masks, write-ignore, forced-zero reads, and a side effect that mirrors a window's low-decode value into its remap register.

The block also drives the decoded base and length of the first bus segment's I/O window as plain outputs. An address-decode stage downstream uses them to steer CPU cycles. The bus model is a simple one: a write strobe takes effect on the clock edge, and read data is returned from a register one cycle after the read strobe.

Top module: `hb_decode_regs`

## Requirements
- R1: The slot index is address bits [11:2]. Address bits above bit 11 and bits [1:0] have no effect, so any two addresses that agree in bits [11:2] reach the same slot.
- R2: A write to one of the six window low-decode slots (word index 0x012, 0x016, 0x020, 0x024, 0x028, 0x02C) stores `wdata & 0x7FFF`. The same write stores `wdata & 0x7FF` into the paired remap slot (0x03C, 0x03E, 0x040, 0x042, 0x044, 0x046, paired in that order).
- R3: Writes to the high-decode slots (0x014, 0x018, 0x022, 0x026, 0x02A, 0x02E) store `wdata & 0x7F`. Direct writes to the remap slots store `wdata & 0x7FF`.
- R4: Writes to the two command slots (0x300, 0x320) store `wdata & 0x0401FC0F`. Writes to the configuration-address slot (0x33E) store `wdata & 0x80FFFFFC`.
- R5: The error-report slots (0x01C, 0x01E, 0x04A, 0x04C, 0x04E) and the ECC slots (0x120 to 0x124) ignore writes and always read zero. The multiprocessor slot (0x048) ignores writes and reads its reset value of zero.
- R6: `io_base` equals the slot 0x012 value shifted left by 21. `io_len` equals `((slot 0x014) + 1 - (slot 0x012 & 0x7F)) << 21`, taken modulo 2^36. Both outputs change on the clock edge that follows the edge where the write is stored.
- R7: At reset the low/high decode pairs hold 0x080/0x0F, 0x090/0x1F, 0x790/0x1F, 0x100/0x0F, 0x110/0x1F and 0x120/0x2F, in the slot order of R2 and R3. Each remap slot starts equal to its low-decode slot.
- R8: With `BIG_ENDIAN = 0`, the CPU-configuration slot (0x000) resets to 0x800 and both command slots reset to 0x00010001. With `BIG_ENDIAN = 1`, all three reset to zero.
- R9: Every other slot stores all 32 bits of a write, reads back the last value stored, and resets to zero.
- R10: `rdata` holds the value of the slot addressed at the edge where `rd_en` is sampled high, starting the cycle after that edge, and holds that value until the next read. A read and a write to the same slot in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (32) | Byte address; only bits [11:2] are decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| io_base | output | 36 | Decoded start address of the first segment's I/O window |
| io_len | output | 36 | Decoded length of the first segment's I/O window |

## Verification
The bench aims at the pairing between each low-decode slot and its remap slot. A wrong pairing or a missing copy leaves a stale remap value that a later read exposes. It pushes the window length through wrap-around by setting a low-decode field above the high-decode value plus one. A design that clamps the result, or uses too few bits, then reports a length other than the modular one. It also drives a read and a write to the same slot in one cycle, and addresses that differ only above bit 11. Forwarding new write data or decoding too many address bits shows up there as a mismatched read. Writes of all ones into the zero-read and write-ignore slots show any leak of stored data.

// File: rtl/hb_regs_pkg.sv
package hb_regs_pkg;

    localparam int SLOT_W = 10;
    localparam int N_WIN  = 6;
    localparam int DATA_W = 32;

    localparam logic [SLOT_W-1:0] IX_CPU   = 10'h000;
    localparam logic [SLOT_W-1:0] IX_MULTI = 10'h048;
    localparam logic [SLOT_W-1:0] IX_CMD0  = 10'h300;
    localparam logic [SLOT_W-1:0] IX_CMD1  = 10'h320;
    localparam logic [SLOT_W-1:0] IX_CFGA  = 10'h33E;

    localparam logic [SLOT_W-1:0] LOW_IX   [N_WIN] = '{10'h012, 10'h016, 10'h020, 10'h024, 10'h028, 10'h02C};
    localparam logic [SLOT_W-1:0] HIGH_IX  [N_WIN] = '{10'h014, 10'h018, 10'h022, 10'h026, 10'h02A, 10'h02E};
    localparam logic [SLOT_W-1:0] REMAP_IX [N_WIN] = '{10'h03C, 10'h03E, 10'h040, 10'h042, 10'h044, 10'h046};
    localparam logic [DATA_W-1:0] LOW_RST  [N_WIN] = '{32'h080, 32'h090, 32'h790, 32'h100, 32'h110, 32'h120};
    localparam logic [DATA_W-1:0] HIGH_RST [N_WIN] = '{32'h0F, 32'h1F, 32'h1F, 32'h0F, 32'h1F, 32'h2F};

    localparam logic [DATA_W-1:0] M_LOW   = 32'h0000_7FFF;
    localparam logic [DATA_W-1:0] M_HIGH  = 32'h0000_007F;
    localparam logic [DATA_W-1:0] M_REMAP = 32'h0000_07FF;
    localparam logic [DATA_W-1:0] M_CMD   = 32'h0401_FC0F;
    localparam logic [DATA_W-1:0] M_CFGA  = 32'h80FF_FFFC;

    typedef struct packed {
        logic              we;
        logic [SLOT_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } slot_wr_t;

    // Error-report and ECC slots: forced-zero reads.
    function automatic logic is_zero_slot(input logic [SLOT_W-1:0] ix);
        return (ix == 10'h01C) || (ix == 10'h01E) || (ix == 10'h04A) ||
               (ix == 10'h04C) || (ix == 10'h04E) ||
               (ix >= 10'h120 && ix <= 10'h124);
    endfunction

    function automatic logic is_high_slot(input logic [SLOT_W-1:0] ix);
        logic hit = 1'b0;
        for (int k = 0; k < N_WIN; k++) hit |= (ix == HIGH_IX[k]);
        return hit;
    endfunction

    function automatic logic is_remap_slot(input logic [SLOT_W-1:0] ix);
        logic hit = 1'b0;
        for (int k = 0; k < N_WIN; k++) hit |= (ix == REMAP_IX[k]);
        return hit;
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input logic [SLOT_W-1:0] ix,
                                                      input bit big_endian);
        logic [DATA_W-1:0] v = '0;
        for (int k = 0; k < N_WIN; k++) begin
            if (ix == LOW_IX[k] || ix == REMAP_IX[k]) v = LOW_RST[k];
            if (ix == HIGH_IX[k]) v = HIGH_RST[k];
        end
        if (!big_endian && ix == IX_CPU) v = 32'h0000_0800;
        if (!big_endian && (ix == IX_CMD0 || ix == IX_CMD1)) v = 32'h0001_0001;
        return v;
    endfunction

endpackage

// File: rtl/hb_write_filter.sv
module hb_write_filter
    import hb_regs_pkg::*;
(
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output slot_wr_t          prim,
    output slot_wr_t          side
);
    logic [N_WIN-1:0] low_hit;

    // One comparator per window, picking the low-decode slot and its remap partner.
    for (genvar w = 0; w < N_WIN; w++) begin : g_low
        assign low_hit[w] = (idx == LOW_IX[w]);
    end

    always_comb begin
        logic [DATA_W-1:0] mask_d;
        mask_d = '1;
        if (|low_hit)            mask_d = M_LOW;
        else if (is_high_slot(idx))  mask_d = M_HIGH;
        else if (is_remap_slot(idx)) mask_d = M_REMAP;
        else if (idx == IX_CMD0 || idx == IX_CMD1) mask_d = M_CMD;
        else if (idx == IX_CFGA) mask_d = M_CFGA;

        prim.we   = wr_en && !is_zero_slot(idx) && (idx != IX_MULTI);
        prim.idx  = idx;
        prim.data = wdata & mask_d;

        side.we   = wr_en && (|low_hit);
        side.idx  = '0;
        side.data = wdata & M_REMAP;
        for (int k = 0; k < N_WIN; k++)
            if (low_hit[k]) side.idx = REMAP_IX[k];
    end

endmodule

// File: rtl/hb_word_store.sv
module hb_word_store
    import hb_regs_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_wr_t          prim,
    input  slot_wr_t          side,
    input  logic              rd_en,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] win_low,
    output logic [DATA_W-1:0] win_high
);
    localparam int N_SLOT = 1 << SLOT_W;

    logic [DATA_W-1:0] mem_q [N_SLOT];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = is_zero_slot(rd_idx) ? '0 : mem_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            for (int i = 0; i < N_SLOT; i++)
                mem_q[i] <= reset_value(SLOT_W'(i), BIG_ENDIAN);
        end else begin
            rd_q <= rd_d;
            if (prim.we) mem_q[prim.idx] <= prim.data;
            if (side.we) mem_q[side.idx] <= side.data;
        end
    end

    assign rdata    = rd_q;
    assign win_low  = mem_q[LOW_IX[0]];
    assign win_high = mem_q[HIGH_IX[0]];

    p_zero_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_zero_slot(rd_idx) |=> rdata == '0);
    p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    p_cmd_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_idx == IX_CMD0 || rd_idx == IX_CMD1) |=> (rdata & ~M_CMD) == '0);
    p_high_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_high_slot(rd_idx) |=> (rdata & ~M_HIGH) == '0);

endmodule

// File: rtl/hb_window_calc.sv
module hb_window_calc
    import hb_regs_pkg::*;
#(
    parameter int SHIFT    = 21,
    parameter int LOW_BITS = 15,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_seen,
    input  logic [DATA_W-1:0]         low,
    input  logic [DATA_W-1:0]         high,
    output logic [LOW_BITS+SHIFT-1:0] base,
    output logic [LOW_BITS+SHIFT-1:0] len
);
    localparam int WIN_W = LOW_BITS + SHIFT;

    typedef struct packed {
        logic [WIN_W-1:0] base;
        logic [WIN_W-1:0] len;
    } win_t;

    win_t win_d, win_q, win_rst;
    logic wr_d1_q;

    function automatic win_t decode(input logic [DATA_W-1:0] lo, input logic [DATA_W-1:0] hi);
        win_t r;
        logic [WIN_W-1:0] span;
        span   = WIN_W'(hi) + WIN_W'(1) - WIN_W'(lo[6:0]);
        r.base = WIN_W'(lo[LOW_BITS-1:0]) << SHIFT;
        r.len  = span << SHIFT;
        return r;
    endfunction

    always_comb begin
        win_rst = decode(reset_value(LOW_IX[0], BIG_ENDIAN), reset_value(HIGH_IX[0], BIG_ENDIAN));
        win_d   = decode(low, high);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= win_rst;
            wr_d1_q <= 1'b0;
        end else begin
            win_q   <= win_d;
            wr_d1_q <= wr_seen;
        end
    end

    assign base = win_q.base;
    assign len  = win_q.len;

    p_win_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_seen && !wr_d1_q |=> $stable(base) && $stable(len));
    p_win_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        base[SHIFT-1:0] == '0 && len[SHIFT-1:0] == '0);

endmodule

// File: rtl/hb_decode_regs.sv
module hb_decode_regs
    import hb_regs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0,
    parameter int WIN_SHIFT  = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [15+WIN_SHIFT-1:0] io_base,
    output logic [15+WIN_SHIFT-1:0] io_len
);
    localparam int LOW_BITS = 15;

    logic [SLOT_W-1:0] idx;
    slot_wr_t          prim, side;
    logic [DATA_W-1:0] win_low, win_high;

    // R1: only the word-slot bits of the 4 KB window are decoded.
    assign idx = addr[SLOT_W+1:2];

    hb_write_filter u_filter (
        .wr_en (wr_en),
        .idx   (idx),
        .wdata (wdata),
        .prim  (prim),
        .side  (side)
    );

    hb_word_store #(.BIG_ENDIAN(BIG_ENDIAN)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .prim     (prim),
        .side     (side),
        .rd_en    (rd_en),
        .rd_idx   (idx),
        .rdata    (rdata),
        .win_low  (win_low),
        .win_high (win_high)
    );

    hb_window_calc #(.SHIFT(WIN_SHIFT), .LOW_BITS(LOW_BITS), .BIG_ENDIAN(BIG_ENDIAN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_seen (wr_en),
        .low     (win_low),
        .high    (win_high),
        .base    (io_base),
        .len     (io_len)
    );

endmodule

// File: tb/hb_decode_regs_tb.sv
module hb_decode_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [31:0] rdata, rdata_be;
    logic [35:0] io_base, io_len, io_base_be, io_len_be;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    hb_decode_regs #(.BIG_ENDIAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .io_base(io_base), .io_len(io_len));

    hb_decode_regs #(.BIG_ENDIAN(1'b1)) u_dut_be (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_be), .io_base(io_base_be), .io_len(io_len_be));

    // Behavioural reference model
    logic [31:0] model [1024];
    logic [31:0] exp_rd;
    logic [35:0] exp_base, exp_len;

    function automatic int remap_of(int ix);
        case (ix)
            'h012: return 'h03C;  'h016: return 'h03E;  'h020: return 'h040;
            'h024: return 'h042;  'h028: return 'h044;  'h02C: return 'h046;
            default: return -1;
        endcase
    endfunction

    function automatic bit reads_zero(int ix);
        return ix == 'h01C || ix == 'h01E || ix == 'h04A || ix == 'h04C ||
               ix == 'h04E || (ix >= 'h120 && ix <= 'h124);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) model[i] = 32'h0;
        model['h000] = 32'h800;
        model['h300] = 32'h00010001;  model['h320] = 32'h00010001;
        model['h012] = 'h080; model['h014] = 'h0F; model['h03C] = 'h080;
        model['h016] = 'h090; model['h018] = 'h1F; model['h03E] = 'h090;
        model['h020] = 'h790; model['h022] = 'h1F; model['h040] = 'h790;
        model['h024] = 'h100; model['h026] = 'h0F; model['h042] = 'h100;
        model['h028] = 'h110; model['h02A] = 'h1F; model['h044] = 'h110;
        model['h02C] = 'h120; model['h02E] = 'h2F; model['h046] = 'h120;
    endtask

    task automatic model_write(int ix, logic [31:0] d);
        if (reads_zero(ix) || ix == 'h048) return;
        if (remap_of(ix) >= 0) begin
            model[ix] = d & 32'h7FFF;
            model[remap_of(ix)] = d & 32'h7FF;
        end else if (ix == 'h014 || ix == 'h018 || ix == 'h022 || ix == 'h026 ||
                     ix == 'h02A || ix == 'h02E)
            model[ix] = d & 32'h7F;
        else if (ix >= 'h03C && ix <= 'h046 && ix[0] == 1'b0)
            model[ix] = d & 32'h7FF;
        else if (ix == 'h300 || ix == 'h320)
            model[ix] = d & 32'h0401FC0F;
        else if (ix == 'h33E)
            model[ix] = d & 32'h80FFFFFC;
        else
            model[ix] = d;
    endtask

    task automatic model_window(output logic [35:0] b, output logic [35:0] l);
        logic [35:0] lo, hi;
        lo = 36'(model['h012] & 32'h7FFF);
        hi = 36'(model['h014]);
        b  = lo << 21;
        l  = (hi + 36'd1 - (lo & 36'h7F)) << 21;
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, model the rising edge, compare at the next falling edge.
    task automatic cyc(bit wr, bit rd, logic [31:0] a, logic [31:0] d, string req);
        int ix;
        logic [35:0] nb, nl;
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        ix = int'(a[11:2]);
        @(posedge clk);
        if (rd) exp_rd = reads_zero(ix) ? 32'h0 : model[ix];
        model_window(nb, nl);
        exp_base = nb; exp_len = nl;
        if (wr) model_write(ix, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(req, 64'(rdata), 64'(exp_rd));
        check("R6 base", 64'(io_base), 64'(exp_base));
        check("R6 len", 64'(io_len), 64'(exp_len));
    endtask

    task automatic rd_chk(logic [31:0] a, string req);
        cyc(1'b0, 1'b1, a, 32'h0, req);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam int NA = 24;
    logic [31:0] pool [NA] = '{32'h048, 32'h050, 32'h058, 32'h060, 32'h080, 32'h088,
                               32'h090, 32'h098, 32'h0A0, 32'h0A8, 32'h0B0, 32'h0B8,
                               32'h0F0, 32'h0F8, 32'h118, 32'h070, 32'h480, 32'h120,
                               32'hC00, 32'hC80, 32'hCF8, 32'h404, 32'h7FC, 32'h000};

    initial begin
        model_reset();
        exp_rd = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7 / R8: reset state
        model_window(exp_base, exp_len);
        check("R7 reset base", 64'(io_base), 64'(exp_base));
        check("R7 reset len", 64'(io_len), 64'(exp_len));
        check("R8 be reset len", 64'(io_len_be), 64'(exp_len));
        rd_chk(32'h000, "R8 cpu cfg reset");
        check("R8 be cpu cfg", 64'(rdata_be), 64'h0);
        rd_chk(32'hC00, "R8 cmd0 reset");
        check("R8 be cmd0", 64'(rdata_be), 64'h0);
        rd_chk(32'hC80, "R8 cmd1 reset");
        check("R8 be cmd1", 64'(rdata_be), 64'h0);
        rd_chk(32'h0B0, "R7 m1 low reset");
        rd_chk(32'h118, "R7 remap reset");
        rd_chk(32'h0B8, "R7 high reset");

        // R2: low-decode write and remap copy
        cyc(1'b1, 1'b0, 32'h048, 32'hFFFF_ABCD, "R2 write");
        rd_chk(32'h048, "R2 low masked");
        rd_chk(32'h0F0, "R2 remap copy");
        cyc(1'b1, 1'b0, 32'h0B0, 32'h1234_5678, "R2 write m1");
        rd_chk(32'h118, "R2 remap pair m1");
        rd_chk(32'h0F0, "R2 other remap untouched");

        // R3
        cyc(1'b1, 1'b0, 32'h050, 32'hFFFF_FFFF, "R3 write");
        rd_chk(32'h050, "R3 high mask");
        cyc(1'b1, 1'b0, 32'h0F8, 32'hFFFF_FFFF, "R3 write");
        rd_chk(32'h0F8, "R3 remap mask");

        // R4
        cyc(1'b1, 1'b0, 32'hC00, 32'hFFFF_FFFF, "R4 write");
        rd_chk(32'hC00, "R4 cmd mask");
        cyc(1'b1, 1'b0, 32'hCF8, 32'hFFFF_FFFF, "R4 write");
        rd_chk(32'hCF8, "R4 cfg addr mask");

        // R5
        cyc(1'b1, 1'b0, 32'h070, 32'hFFFF_FFFF, "R5 write");
        rd_chk(32'h070, "R5 error slot zero");
        cyc(1'b1, 1'b0, 32'h488, 32'hFFFF_FFFF, "R5 write");
        rd_chk(32'h488, "R5 ecc slot zero");
        cyc(1'b1, 1'b0, 32'h120, 32'hFFFF_FFFF, "R5 write");
        rd_chk(32'h120, "R5 multi ignores");

        // R9 / R1
        cyc(1'b1, 1'b0, 32'h400, 32'hDEAD_BEEF, "R9 write");
        rd_chk(32'h400, "R9 plain readback");
        rd_chk(32'hABCD_E403, "R1 alias read");
        cyc(1'b1, 1'b0, 32'h5555_5404, 32'hCAFE_F00D, "R1 alias write");
        rd_chk(32'h404, "R1 alias landed");

        // R10: same-cycle read/write returns old value, then hold
        cyc(1'b1, 1'b1, 32'h404, 32'h0BAD_0BAD, "R10 read-during-write old");
        cyc(1'b0, 1'b0, 32'h404, 32'h0, "R10 hold");
        rd_chk(32'h404, "R10 new value");

        // R6: wrap-around of length
        cyc(1'b1, 1'b0, 32'h048, 32'h0000_007F, "R6 low");
        cyc(1'b1, 1'b0, 32'h050, 32'h0000_0000, "R6 high");
        cyc(1'b0, 1'b0, 32'h0, 32'h0, "R6 settle");

        // Mixed traffic over the special and plain slots
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            a = pool[$urandom_range(NA - 1)] | ({$urandom} & 32'hFFFF_F003);
            cyc(1'($urandom), 1'($urandom), a, $urandom, "R9 mixed traffic");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule